// File: doc/BRIEF.md
# Luminance Unsharp-Mask Sharpener

This block sharpens a raster stream of 8-bit luminance samples. For each pixel it takes the 3x3 neighbourhood around it and forms the mean of the nine samples. It subtracts that mean from the centre sample to get the local detail. The detail is scaled by a programmable gain and added back to the centre sample. The sum is then saturated to the 8-bit range. Samples on the outer ring of the frame are forwarded untouched.

The stream is beat-based: a beat is any cycle with `in_valid` high. The block keeps the previous two lines in circular line buffers. A window is complete one line plus one pixel after its centre sample arrives. Each output beat therefore carries the pixel that entered IMG_W+1 beats earlier, together with that pixel's line and frame markers. The tail of one frame leaves the block while the head of the next frame enters. Idle cycles between beats stall the whole stream, and every output is registered once.

Top module: `luma_sharpen`

## Requirements
- R1: `out_valid` is high in the cycle after each input beat and low in the cycle after each idle cycle. After an idle cycle, `out_pix`, `out_sol` and `out_sof` keep their previous values. Reset drives all outputs to 0.
- R2: Output beat k carries the result for input beat k-(IMG_W+1). For the first IMG_W+1 output beats after reset, the pixel and both markers are 0.
- R3: `out_sol` and `out_sof` are the `in_sol` and `in_sof` values of the same delayed input beat. An input beat with `in_sof` high is taken as row 0, column 0 of an IMG_W x IMG_H frame, and the position count restarts there.
- R4: A pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 is output equal to its input value.
- R5: For an inner pixel, the mean is floor(S*57/512), where S is the unsigned sum of the nine window samples.
- R6: The detail is the centre minus the mean, a signed value. The added term is floor(detail*gain/4), an arithmetic shift right by 2 of the signed product.
- R7: For an inner pixel, the output is centre + added term, clipped to 0 below and to 255 above.
- R8: `gain` is an unsigned 4-bit value sampled on the input beat that completes the window. With gain 0, inner pixels pass through unchanged.
- R9: Gains 4, 7 and 9 give gains of 1.0, 1.75 and 2.25 under the rules of R5 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 8 | Input luminance sample |
| gain | input | 4 | Detail gain in quarter steps |
| out_valid | output | 1 | Output beat qualifier |
| out_sol | output | 1 | Delayed line-start marker |
| out_sof | output | 1 | Delayed frame-start marker |
| out_pix | output | 8 | Sharpened sample |

## Verification
The bench drives a sequence of frames, each chosen to exercise a different path:
- A smooth ramp at gain 4 exposes errors in the mean arithmetic and in the window alignment.
- A 0/255 checkerboard at gain 9 drives every inner pixel into both clip limits.
- Random content with the gain changing on every beat, and with idle gaps, shows whether the gain is sampled on the completing beat and whether stalls keep the stream aligned.
- A flat frame at gain 15 must come out unchanged, because its detail is zero.
- Random frames at gains 0 and 7 separate the bypass path from true sharpening.

Border positions are checked across all of these frames.

// File: rtl/luma_sharpen.sv
module luma_sharpen #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int DW    = 8,
  parameter int GW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic [DW-1:0] in_pix,
  input  logic [GW-1:0] gain,
  output logic          out_valid,
  output logic          out_sol,
  output logic          out_sof,
  output logic [DW-1:0] out_pix
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);
  localparam int SW = DW + 4;
  localparam int MW = SW + 6;
  localparam int EW = DW + 2;
  localparam int PW = EW + GW + 1;
  localparam int LW = DW + 2;

  logic [LW-1:0] lb1 [IMG_W];
  logic [DW-1:0] lb2 [IMG_W];
  logic [CW-1:0] ptr;
  logic [DW-1:0] a1, a2, b2, c1, c2;
  logic [LW-1:0] b1;
  logic [RW-1:0] crow_q, crow;
  logic [CW-1:0] ccol_q, ccol;

  wire [LW-1:0] b0 = lb1[ptr];
  wire [DW-1:0] c0 = lb2[ptr];
  wire [DW-1:0] ctr_pix = b1[DW-1:0];

  always_comb begin
    if (in_sof) begin
      crow = RW'(IMG_H - 2);
      ccol = CW'(IMG_W - 1);
    end else if (ccol_q == CW'(IMG_W - 1)) begin
      ccol = '0;
      crow = (crow_q == RW'(IMG_H - 1)) ? '0 : crow_q + 1'b1;
    end else begin
      ccol = ccol_q + 1'b1;
      crow = crow_q;
    end
  end

  wire border = (crow == '0) || (crow == RW'(IMG_H - 1)) ||
                (ccol == '0) || (ccol == CW'(IMG_W - 1));

  wire [SW-1:0] sum = SW'(in_pix) + SW'(a1) + SW'(a2) +
                      SW'(b0[DW-1:0]) + SW'(ctr_pix) + SW'(b2) +
                      SW'(c0) + SW'(c1) + SW'(c2);
  wire [MW-1:0] msc  = MW'(sum) * MW'(57);
  wire [DW-1:0] mean = DW'(msc >> 9);

  wire signed [EW-1:0] detail = $signed({2'b00, ctr_pix}) - $signed({2'b00, mean});
  wire signed [PW-1:0] prod   = PW'(detail) * PW'($signed({1'b0, gain}));
  wire signed [PW-1:0] added  = prod >>> 2;
  wire signed [PW-1:0] total  = $signed({{(PW-DW){1'b0}}, ctr_pix}) + added;

  logic [DW-1:0] clipped;
  always_comb begin
    if (total < 0)                                    clipped = '0;
    else if (total > $signed(PW'((1 << DW) - 1)))     clipped = '1;
    else                                              clipped = total[DW-1:0];
  end

  wire [DW-1:0] result = border ? ctr_pix : clipped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IMG_W; i++) begin
        lb1[i] <= '0;
        lb2[i] <= '0;
      end
      ptr    <= '0;
      a1     <= '0;
      a2     <= '0;
      b1     <= '0;
      b2     <= '0;
      c1     <= '0;
      c2     <= '0;
      crow_q <= RW'(IMG_H - 2);
      ccol_q <= CW'(IMG_W - 2);
    end else if (in_valid) begin
      lb1[ptr] <= {in_sof, in_sol, in_pix};
      lb2[ptr] <= b0[DW-1:0];
      ptr      <= (ptr == CW'(IMG_W - 1)) ? '0 : ptr + 1'b1;
      a1       <= in_pix;
      a2       <= a1;
      b1       <= b0;
      b2       <= ctr_pix;
      c1       <= c0;
      c2       <= c1;
      crow_q   <= crow;
      ccol_q   <= ccol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pix <= result;
        out_sol <= b1[DW];
        out_sof <= b1[DW+1];
      end
    end
  end
endmodule

// File: rtl/luma_sharpen_chk.sv
module luma_sharpen_chk #(
  parameter int DW = 8,
  parameter int GW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [GW-1:0] gain,
  input logic          out_valid,
  input logic [DW-1:0] out_pix,
  input logic [DW-1:0] ctr_pix,
  input logic          border
);
  p_beat_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_pix)));

  p_ring_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && border) |=> (out_pix == $past(ctr_pix)));

  p_zero_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == '0) |=> (out_pix == $past(ctr_pix)));
endmodule

bind luma_sharpen luma_sharpen_chk #(.DW(DW), .GW(GW)) u_chk (.*);

// File: tb/tb_luma_sharpen.sv
module tb_luma_sharpen;
  localparam int W = 8;
  localparam int H = 6;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0, in_sol = 0, in_sof = 0;
  logic [7:0] in_pix = 0;
  logic [3:0] gain = 0;
  logic       out_valid, out_sol, out_sof;
  logic [7:0] out_pix;

  always #2 clk = ~clk;

  luma_sharpen #(.IMG_W(W), .IMG_H(H)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .gain(gain), .out_valid(out_valid),
    .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix));

  int hist_pix [2048];
  int hist_gain[2048];
  int n_in = 0, n_out = 0, checks = 0, fails = 0;
  bit last_v = 0;
  int prev_pix = 0, prev_sol = 0, prev_sof = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (out beat %0d)", tag, act, exp, n_out);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'((seed >> 16) & 8'hff);
  endfunction

  function automatic bit on_ring(int j);
    int r = (j / W) % H;
    int c = j % W;
    return (r == 0) || (r == H-1) || (c == 0) || (c == W-1);
  endfunction

  // model of R5, R6, R7
  function automatic int model(int k);
    int j = k - W - 1;
    int s = 0, m, d, a, t, g;
    if (j < 0) return 0;
    if (on_ring(j)) return hist_pix[j];
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        s += hist_pix[j + dr*W + dc];
    m = (s * 57) >>> 9;
    d = hist_pix[j] - m;
    g = hist_gain[k];
    a = (d * g) >>> 2;
    t = hist_pix[j] + a;
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  function automatic string tag_of(int k);
    int j = k - W - 1;
    int s = 0, raw;
    if (j < 0) return "R2";
    if (on_ring(j)) return "R4";
    if (hist_gain[k] == 0) return "R8";
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        s += hist_pix[j + dr*W + dc];
    raw = hist_pix[j] + (((hist_pix[j] - ((s * 57) >>> 9)) * hist_gain[k]) >>> 2);
    if (raw < 0 || raw > 255) return "R7";
    if (hist_gain[k] == 4 || hist_gain[k] == 7 || hist_gain[k] == 9) return "R9";
    return "R5/R6";
  endfunction

  task automatic compare();
    if (last_v) begin
      int j = n_out - W - 1;
      int e = model(n_out);
      int es = (j >= 0) ? int'(j % W == 0) : 0;
      int ef = (j >= 0) ? int'(j % (W*H) == 0) : 0;
      check(out_valid === 1'b1, "R1 valid", int'(out_valid), 1);
      check(int'(out_pix) == e, tag_of(n_out), int'(out_pix), e);
      check(int'(out_sol) == es, "R3 sol", int'(out_sol), es);
      check(int'(out_sof) == ef, "R2 R3 sof", int'(out_sof), ef);
      n_out++;
    end else begin
      check(out_valid === 1'b0, "R1 idle valid", int'(out_valid), 0);
      check(int'(out_pix) == prev_pix && int'(out_sol) == prev_sol && int'(out_sof) == prev_sof,
            "R1 hold", int'(out_pix), prev_pix);
    end
    prev_pix = int'(out_pix);
    prev_sol = int'(out_sol);
    prev_sof = int'(out_sof);
  endtask

  task automatic cycle(bit v, int r, int c, int p, int g);
    @(negedge clk);
    compare();
    in_valid = v;
    in_sol   = v && (c == 0);
    in_sof   = v && (r == 0) && (c == 0);
    in_pix   = 8'(p);
    gain     = 4'(g);
    if (v) begin
      hist_pix[n_in]  = p;
      hist_gain[n_in] = g;
      n_in++;
    end
    last_v = v;
  endtask

  task automatic frame(int kind, int g, bit gaps);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int p, gg;
        case (kind)
          0: p = (r * 37 + c * 11) & 255;
          1: p = ((r + c) & 1) ? 255 : 0;
          3: p = 100;
          default: p = rnd();
        endcase
        gg = (g < 0) ? ((r * W + c) % 16) : g;
        if (gaps && (c % 3 == 2)) cycle(0, 0, 0, rnd(), rnd() & 15);
        cycle(1, r, c, p, gg);
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_pix === 8'd0, "R1 reset", int'(out_pix), 0);
    check(out_sol === 1'b0 && out_sof === 1'b0, "R1 reset markers", int'(out_sof), 0);
    rst_n = 1;
    frame(0, 4, 0);    // ramp, R9 gain 1.0
    frame(1, 9, 0);    // checkerboard, R7 both clip limits
    frame(2, -1, 1);   // random, per-beat gain (R8 sampling), idle gaps (R1)
    frame(3, 15, 0);   // flat, zero detail (R6)
    frame(4, 0, 0);    // random, bypass R8
    frame(5, 7, 1);    // random, R9 gain 1.75
    frame(0, 4, 0);    // flush
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual %0d expected %0d", n_out, n_in);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule